// File: doc/BRIEF.md
# ECC Error Address and Status Logger

This block sits beside a memory controller's ECC checker. It records where the first ECC error was seen and what kind it was. The checker raises a one-cycle strobe for a corrected (single-bit) error or an uncorrectable (multi-bit) error. It also presents the failing byte address and the syndrome. The logger keeps the upper address bits and the syndrome of the first such event in one 32-bit status word, and sets the flag for that error type. It then ignores every later error until software writes the word back with a 1 in either flag position. That write clears both flags and arms capture again.

The same word holds three control bits that software can read and write:
- a scrub-inhibit bit,
- an enable for the alert on an uncorrectable error,
- an enable for the non-maskable interrupt on a corrected error.

Each alert is a level that stays high while its flag and its enable are both set. A separate one-cycle scrub request follows every corrected read, whether or not capture is frozen, unless scrubbing is inhibited.

Because only the top 19 bits of a 33-bit byte address are kept, the captured address locates the error to a 16 KiB (2^14 byte) region.

Top module: `ecc_err_logger`

## Requirements
- R1: After synchronous reset the status word reads 0 and nmi_req, bus_err_req and scrub_req are low.
- R2: A corrected-error strobe while no flag is set sets bit 0 on the next clock edge. On the same edge, err_addr[32:14] is stored in bits 30:12 and err_syndrome in bits 11:4.
- R3: An uncorrectable-error strobe while no flag is set sets bit 1 on the next clock edge, and stores the address and syndrome the same way.
- R4: When both strobes arrive in the same cycle while armed, the uncorrectable error wins: only bit 1 is set, and its address and syndrome are stored.
- R5: While bit 0 or bit 1 is set, further strobes of either type leave bits 30:0 unchanged.
- R6: A write with a 1 in bit 0 or in bit 1 clears both flags. A write with 0 in both bits leaves the flags as they were. The address and syndrome fields keep their values until the next capture.
- R7: If a clearing write and an error strobe occur in the same cycle, the flags are cleared and the new error is captured on that same edge.
- R8: Every write loads bit 31 (scrub inhibit), bit 3 (uncorrectable alert enable) and bit 2 (corrected interrupt enable). Written values in bits 30:4 are ignored.
- R9: nmi_req is high exactly while bit 0 and bit 2 are both 1.
- R10: bus_err_req is high exactly while bit 1 and bit 3 are both 1.
- R11: scrub_req is high for the single cycle after a cycle with the corrected strobe set, the uncorrectable strobe clear and bit 31 equal to 0. This holds whatever the flag state. It is never high when bit 31 was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the status word |
| cfg_wr_data | input | 32 | Write data for the status word |
| cfg_rd_data | output | 32 | Current status word |
| err_single | input | 1 | Corrected (single-bit) error strobe |
| err_multi | input | 1 | Uncorrectable (multi-bit) error strobe |
| err_addr | input | 33 | Byte address of the access in error |
| err_syndrome | input | 8 | ECC syndrome of the access in error |
| nmi_req | output | 1 | Interrupt request for a captured corrected error |
| bus_err_req | output | 1 | Alert for a captured uncorrectable error |
| scrub_req | output | 1 | Write-back scrub request after a corrected read |

## Verification
The bench goes after four corner cases:
- An error of the other type arriving while capture is frozen. A design that overwrote the word would report the wrong first failure.
- A write that touches only one flag. Clearing just that flag would leave capture locked forever.
- A clearing write in the same cycle as a new error. Letting the stale freeze win would lose that error.
- Simultaneous strobes, and scrub requests issued during a freeze or with scrubbing inhibited. A design that got these wrong would set two flags at once, or scrub data that must not be written back.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  // Fixed low positions of the status word; upper fields derive from sizes.
  localparam int FLAG_SINGLE_BIT = 0;
  localparam int FLAG_MULTI_BIT  = 1;
  localparam int NMI_EN_BIT      = 2;
  localparam int BUSERR_EN_BIT   = 3;
  localparam int SYN_LSB         = 4;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_SINGLE = 2'd1,
    EV_MULTI  = 2'd2
  } err_ev_e;
endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status
  import ecc_log_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic err_single,
  input  logic err_multi,
  output logic capture_en,
  output logic flag_single,
  output logic flag_multi
);
  err_ev_e ev;
  logic    armed;
  logic    fs_d, fm_d;

  // Uncorrectable errors take priority when both strobes coincide.
  always_comb begin
    if (err_multi)       ev = EV_MULTI;
    else if (err_single) ev = EV_SINGLE;
    else                 ev = EV_NONE;
  end

  always_comb begin
    armed      = !(flag_single || flag_multi) || clr;
    capture_en = armed && (ev != EV_NONE);
    fs_d       = clr ? 1'b0 : flag_single;
    fm_d       = clr ? 1'b0 : flag_multi;
    if (capture_en) begin
      fs_d = (ev == EV_SINGLE);
      fm_d = (ev == EV_MULTI);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_single <= 1'b0;
      flag_multi  <= 1'b0;
    end else begin
      flag_single <= fs_d;
      flag_multi  <= fm_d;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    !(flag_single && flag_multi)); // R4
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (rst)
    clr && !err_single && !err_multi |=> !flag_single && !flag_multi); // R6
  AST_SINGLE_SET: assert property (@(posedge clk) disable iff (rst)
    !flag_single && !flag_multi && err_single && !err_multi |=> flag_single); // R2
  AST_MULTI_SET: assert property (@(posedge clk) disable iff (rst)
    !flag_single && !flag_multi && err_multi |=> flag_multi); // R3
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_single || flag_multi) && !clr |=> $stable({flag_single, flag_multi})); // R5
endmodule

// File: rtl/ecc_log_hold.sv
module ecc_log_hold #(
  parameter int KEEP_W = 19,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_en,
  input  logic              frozen,
  input  logic [KEEP_W-1:0] addr_hi,
  input  logic [SYN_W-1:0]  syndrome,
  output logic [KEEP_W-1:0] addr_q,
  output logic [SYN_W-1:0]  syn_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      syn_q  <= '0;
    end else if (capture_en) begin
      addr_q <= addr_hi;
      syn_q  <= syndrome;
    end
  end

  // frozen comes from the flag logic: no capture may pass while it is set
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    frozen && !capture_en |=> $stable(addr_q) && $stable(syn_q)); // R5
endmodule

// File: rtl/ecc_log_alert.sv
module ecc_log_alert (
  input  logic clk,
  input  logic rst,
  input  logic err_single,
  input  logic err_multi,
  input  logic scrub_dis,
  input  logic nmi_en,
  input  logic buserr_en,
  input  logic flag_single,
  input  logic flag_multi,
  output logic nmi_req,
  output logic bus_err_req,
  output logic scrub_req
);
  always_ff @(posedge clk) begin
    if (rst) scrub_req <= 1'b0;
    else     scrub_req <= err_single && !err_multi && !scrub_dis;
  end

  assign nmi_req     = flag_single && nmi_en;
  assign bus_err_req = flag_multi && buserr_en;

  AST_SCRUB_ON: assert property (@(posedge clk) disable iff (rst)
    err_single && !err_multi && !scrub_dis |=> scrub_req); // R11
  AST_SCRUB_OFF: assert property (@(posedge clk) disable iff (rst)
    scrub_dis |=> !scrub_req); // R11
  AST_ALERT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(nmi_req && bus_err_req)); // R9
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 33,
  parameter int KEEP_W = 19,
  parameter int SYN_W  = 8,
  localparam int REG_W = SYN_LSB + SYN_W + KEEP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              err_single,
  input  logic              err_multi,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syndrome,
  output logic              nmi_req,
  output logic              bus_err_req,
  output logic              scrub_req
);
  localparam int ADDR_LSB  = SYN_LSB + SYN_W;
  localparam int SCRUB_BIT = ADDR_LSB + KEEP_W;
  localparam int DROP_W    = ADDR_W - KEEP_W;

  logic              clr;
  logic              capture_en;
  logic              flag_single, flag_multi;
  logic [KEEP_W-1:0] addr_q;
  logic [SYN_W-1:0]  syn_q;
  logic              scrub_dis, nmi_en, buserr_en;
  logic              unused_bits;

  assign unused_bits = ^{err_addr[DROP_W-1:0], cfg_wr_data[SCRUB_BIT-1:SYN_LSB]};

  assign clr = cfg_wr_en &&
               (cfg_wr_data[FLAG_SINGLE_BIT] || cfg_wr_data[FLAG_MULTI_BIT]);

  // Control bits: loaded on every write
  always_ff @(posedge clk) begin
    if (rst) begin
      scrub_dis <= 1'b0;
      nmi_en    <= 1'b0;
      buserr_en <= 1'b0;
    end else if (cfg_wr_en) begin
      scrub_dis <= cfg_wr_data[SCRUB_BIT];
      nmi_en    <= cfg_wr_data[NMI_EN_BIT];
      buserr_en <= cfg_wr_data[BUSERR_EN_BIT];
    end
  end

  ecc_log_status u_status (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .err_single  (err_single),
    .err_multi   (err_multi),
    .capture_en  (capture_en),
    .flag_single (flag_single),
    .flag_multi  (flag_multi)
  );

  ecc_log_hold #(
    .KEEP_W (KEEP_W),
    .SYN_W  (SYN_W)
  ) u_hold (
    .clk        (clk),
    .rst        (rst),
    .capture_en (capture_en),
    .frozen     ((flag_single || flag_multi) && !clr),
    .addr_hi    (err_addr[ADDR_W-1 -: KEEP_W]),
    .syndrome   (err_syndrome),
    .addr_q     (addr_q),
    .syn_q      (syn_q)
  );

  ecc_log_alert u_alert (
    .clk         (clk),
    .rst         (rst),
    .err_single  (err_single),
    .err_multi   (err_multi),
    .scrub_dis   (scrub_dis),
    .nmi_en      (nmi_en),
    .buserr_en   (buserr_en),
    .flag_single (flag_single),
    .flag_multi  (flag_multi),
    .nmi_req     (nmi_req),
    .bus_err_req (bus_err_req),
    .scrub_req   (scrub_req)
  );

  assign cfg_rd_data = {scrub_dis, addr_q, syn_q, buserr_en, nmi_en,
                        flag_multi, flag_single};

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> cfg_rd_data == '0 && !scrub_req); // R1
  AST_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    !flag_single && !flag_multi && err_single && err_multi |=> !flag_single); // R4
endmodule

// File: tb/test_ecc_err_logger.sv
module test_ecc_err_logger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        err_single = 1'b0;
  logic        err_multi = 1'b0;
  logic [32:0] err_addr = '0;
  logic [7:0]  err_syndrome = '0;
  logic        nmi_req, bus_err_req, scrub_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  ecc_err_logger i_ecc_err_logger (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .err_single(err_single), .err_multi(err_multi),
    .err_addr(err_addr), .err_syndrome(err_syndrome), .nmi_req(nmi_req),
    .bus_err_req(bus_err_req), .scrub_req(scrub_req)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic        es;
    logic        em;
    logic [18:0] ea;   // upper address bits err_addr[32:14]
    logic [7:0]  sy;
    logic [31:0] er;   // expected status word
    logic        en;   // expected nmi_req
    logic        eb;   // expected bus_err_req
    logic        esc;  // expected scrub_req
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0000_0000, 1'b0, 1'b0, 19'h00000, 8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 idle
    '{1'b1, 32'h0000_000C, 1'b0, 1'b0, 19'h00000, 8'h00, 32'h0000_000C, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 enables
    '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 19'h12345, 8'hA5, 32'h1234_5A5D, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 capture
    '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 19'h7FFFF, 8'h3C, 32'h1234_5A5D, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 frozen
    '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 19'h00001, 8'h01, 32'h1234_5A5D, 1'b1, 1'b0, 1'b1, 4'd11}, // R11 scrub while frozen
    '{1'b1, 32'h0000_000C, 1'b0, 1'b0, 19'h00000, 8'h00, 32'h1234_5A5D, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 write 0 no effect
    '{1'b1, 32'h0000_000D, 1'b0, 1'b0, 19'h00000, 8'h00, 32'h1234_5A5C, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 clear
    '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 19'h40001, 8'h81, 32'h4000_181E, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 multi
    '{1'b1, 32'h0000_0004, 1'b0, 1'b0, 19'h00000, 8'h00, 32'h4000_1816, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 gate off
    '{1'b1, 32'h0000_000E, 1'b1, 1'b0, 19'h00ABC, 8'h5A, 32'h00AB_C5AD, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 clear+error
    '{1'b1, 32'h8000_000F, 1'b0, 1'b0, 19'h00000, 8'h00, 32'h80AB_C5AC, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 nmi drops
    '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 19'h00001, 8'hFF, 32'h8000_1FFD, 1'b1, 1'b0, 1'b0, 4'd11}, // R11 inhibited
    '{1'b1, 32'h0000_0001, 1'b0, 1'b0, 19'h00000, 8'h00, 32'h0000_1FF0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 bit0 clears
    '{1'b0, 32'h0000_0000, 1'b1, 1'b1, 19'h00003, 8'h11, 32'h0000_3112, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 both strobes
    '{1'b1, 32'hFFFF_FFF2, 1'b0, 1'b0, 19'h00000, 8'h00, 32'h8000_3110, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 mid bits ignored
    '{1'b1, 32'h0000_0000, 1'b0, 1'b0, 19'h00000, 8'h00, 32'h0000_3110, 1'b0, 1'b0, 1'b0, 4'd8}   // R8 bit31 cleared
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    cfg_wr_en    = v.wr;
    cfg_wr_data  = v.wd;
    err_single   = v.es;
    err_multi    = v.em;
    err_addr     = {v.ea, 14'h2A5};
    err_syndrome = v.sy;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check32("R1 reset word", cfg_rd_data, 32'h0);
    check1("R1 reset nmi", nmi_req, 1'b0);
    check1("R1 reset buserr", bus_err_req, 1'b0);
    check1("R1 reset scrub", scrub_req, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check32($sformatf("R%0d vec%0d word", VEC[i].req, i), cfg_rd_data, VEC[i].er);
      check1($sformatf("R%0d vec%0d nmi", VEC[i].req, i), nmi_req, VEC[i].en);
      check1($sformatf("R%0d vec%0d buserr", VEC[i].req, i), bus_err_req, VEC[i].eb);
      check1($sformatf("R%0d vec%0d scrub", VEC[i].req, i), scrub_req, VEC[i].esc);
    end

    // R1: reset during a frozen capture returns everything to zero
    drive('{1'b1, 32'h0000_000C, 1'b0, 1'b0, 19'h0, 8'h0, 32'h0, 1'b0, 1'b0, 1'b0, 4'd1});
    drive('{1'b0, 32'h0, 1'b1, 1'b0, 19'h55555, 8'h77, 32'h0, 1'b0, 1'b0, 1'b0, 4'd1});
    check1("R9 nmi before reset", nmi_req, 1'b1);
    @(negedge clk);
    err_single = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check32("R1 mid-run reset word", cfg_rd_data, 32'h0);
    check1("R1 mid-run reset nmi", nmi_req, 1'b0);
    check1("R1 mid-run reset scrub", scrub_req, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R10: uncorrectable alert rises when enable is set after capture
    drive('{1'b0, 32'h0, 1'b0, 1'b1, 19'h00010, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 4'd10});
    check1("R10 buserr disabled", bus_err_req, 1'b0);
    drive('{1'b1, 32'h0000_0008, 1'b0, 1'b0, 19'h0, 8'h0, 32'h0, 1'b0, 1'b0, 1'b0, 4'd10});
    check1("R10 buserr enabled", bus_err_req, 1'b1);
    check32("R10 word", cfg_rd_data, 32'h0001_000A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule